// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small multicycle processor built around a 16-bit accumulator and a 16-bit index register, with NZVC condition flags, a program counter, a stack pointer and a 24-bit instruction register. It reaches a 64 KiB byte-addressed space through one synchronous byte port. A read returns its data on the cycle after the request. Every instruction begins with a one-byte specifier. Register-shift and stop instructions consist of that byte alone. All other instructions carry a further 16-bit operand field, sent high byte first.

The core runs the following operations on either register:
- word load and word store
- byte load and byte store
- add and subtract
- left and right arithmetic shift
- stop

The operand field is used in one of two ways. Mode 000 treats it as the value itself. Mode 001 treats it as a memory address. A stop instruction, or any encoding outside this set, drives the core into a halted state. It stays there until reset. The flags are visible on an output so that an embedding system can observe the outcome of arithmetic.

Top module: `acc_core`

## Requirements
- R1: While reset is held, and directly after it is released, `halted` is 0 and `nzvc` is 0000. In the first cycle after release the core requests a read at address 0x0000.
- R2: Specifier bits 7:4 are the opcode, bit 3 selects the register (0 = accumulator, 1 = index) and bits 2:0 are the mode. The program counter moves past 1 byte for a shift and past 3 bytes for every other instruction.
- R2 (cycle counts): Cycles from issue to the next fetch are as follows.

  | Instruction class | Cycles |
  |---|---|
  | Shift | 2 |
  | Any instruction in mode 000 | 4 |
  | Direct word load, add or subtract | 6 |
  | Direct byte load | 5 |
  | Direct word store | 5 |
  | Direct byte store | 4 |

  A halting specifier raises `halted` 2 cycles after its fetch starts.
- R3: Opcode 0000 halts the core whatever its low four bits are. Once `halted` is 1 it stays 1. While halted the core makes no memory access and `nzvc` stays constant.
- R4: The core halts on any of the following. It performs no further access after the halt.
  - opcodes 0010–0110, 1001, 1010 or 1011
  - opcode 0001 with bits 3:2 not equal to 11
  - any non-shift instruction with a mode other than 000 or 001
- R5: Word load (opcode 1100) writes the 16-bit operand into the selected register. Memory words are big-endian: the lower byte address holds bits 15:8. N is set to bit 15 of the result and Z to (result == 0). V and C are unchanged.
- R6: Byte load (opcode 1101) replaces only bits 7:0 of the selected register and keeps bits 15:8. In mode 000 the new bits come from the low byte of the operand field. N and Z are computed from the whole 16-bit register afterwards.
- R7: Word store (opcode 1110) in mode 001 writes register bits 15:8 to the address and bits 7:0 to the address + 1. A store in mode 000, word or byte, performs no write. No store changes `nzvc`.
- R8: Byte store (opcode 1111) in mode 001 writes register bits 7:0 to the one addressed byte and leaves the neighbouring bytes alone.
- R9: Add (opcode 0111) sets the flags as follows.
  - N: bit 15 of the sum
  - Z: (sum == 0)
  - V: signed overflow
  - C: carry out of bit 15
- R10: Subtract (opcode 1000) forms register minus operand and sets the flags as follows.
  - N: bit 15 of the result
  - Z: (result == 0)
  - V: signed overflow
  - C: 1 when an unsigned borrow occurs (register < operand)
- R11: Shift encodings are 0001110r for a left shift and 0001111r for a right shift, with r choosing the register.
  - Left shift: C = old bit 15, V = old bit 15 XOR old bit 14.
  - Right shift: keeps the sign bit, C = old bit 0, V unchanged.
  - Both shifts update N and Z.
- R12: Every instruction acts only on the register its select bit names. The other register keeps its value.
- R13: Reads and writes never happen in the same cycle. Memory contents after a program match sequential execution of that program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 16 | Byte address of the current access |
| mem_rd | output | 1 | Read request; data returns next cycle |
| mem_wr | output | 1 | Write request for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 8 | Write data byte |
| mem_rdata | input | 8 | Read data for the request of the previous cycle |
| nzvc | output | 4 | Flags: bit 3 N, bit 2 Z, bit 1 V, bit 0 C |
| halted | output | 1 | High once the core has stopped |

## Verification
The directed programs target each arithmetic and flag boundary, with the expected flag values written into the bench:
- Sums that overflow into the sign bit or wrap exactly to zero. A carry or overflow formula with the wrong sign would show up here as a wrong V or C.
- A subtract that borrows from zero. A design that reported carry instead of borrow would invert C.
- A left shift across bits 15 and 14, and a right shift of a negative odd value. Losing the sign bit or taking C from the wrong end fails these.
- A byte load into a register whose upper half is already non-zero. A design that cleared bits 15:8 or computed Z from one byte alone fails this.
- A direct word load against a known byte order. Swapping bytes in the word accesses fails this.

Other programs check the cases where nothing should happen, through memory contents, write counts and cycle counts:
- stores in mode 000
- stop bytes with non-zero low bits
- unused opcodes and illegal modes placed ahead of a store that must never be written

Seeded random programs mixing every instruction are compared against a sequential model of the instruction set.

// File: rtl/acc_pkg.sv
package acc_pkg;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 16;
    localparam int SPEC_W = 8;
    localparam int IR_W   = SPEC_W + WORD_W;
    localparam int FLAG_W = 4;

    typedef enum logic [3:0] {
        ST_FETCH, ST_SPEC, ST_OPHI, ST_OPLO,
        ST_RDHI, ST_RDLO, ST_RDBYTE, ST_WRLO, ST_HALT
    } state_e;

    typedef enum logic [3:0] {
        OP_HALT, OP_ASL, OP_ASR, OP_LDW, OP_LDB,
        OP_STW, OP_STB, OP_ADD, OP_SUB
    } op_e;

    typedef struct packed {
        op_e  op;
        logic use_x;
        logic unary;
        logic immed;
    } dec_t;

    typedef struct packed {
        state_e             st;
        logic [ADDR_W-1:0]  pc;
        logic [WORD_W-1:0]  a;
        logic [WORD_W-1:0]  x;
        logic [WORD_W-1:0]  sp;
        logic [IR_W-1:0]    ir;
        logic [BYTE_W-1:0]  tmp;
        logic [FLAG_W-1:0]  nzvc;
    } core_t;
endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_pkg::*;
(
    input  logic [SPEC_W-1:0] spec,
    output dec_t              dec
);
    logic mode_ok;

    always_comb begin
        mode_ok   = (spec[2:1] == 2'b00);
        dec.op    = OP_HALT;
        dec.use_x = spec[3];
        dec.unary = 1'b0;
        dec.immed = (spec[2:0] == 3'b000);
        case (spec[7:4])
            4'h1: begin
                dec.unary = 1'b1;
                dec.use_x = spec[0];
                if (spec[3:2] == 2'b11) begin
                    dec.op = spec[1] ? OP_ASR : OP_ASL;
                end
            end
            4'h7: if (mode_ok) dec.op = OP_ADD;
            4'h8: if (mode_ok) dec.op = OP_SUB;
            4'hC: if (mode_ok) dec.op = OP_LDW;
            4'hD: if (mode_ok) dec.op = OP_LDB;
            4'hE: if (mode_ok) dec.op = OP_STW;
            4'hF: if (mode_ok) dec.op = OP_STB;
            default: dec.op = OP_HALT;
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
(
    input  op_e               op,
    input  logic [WORD_W-1:0] lhs,
    input  logic [WORD_W-1:0] rhs,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [WORD_W-1:0] res,
    output logic [FLAG_W-1:0] flags_out
);
    logic [WORD_W:0] sum_w;
    logic            v_f;
    logic            c_f;

    always_comb begin
        res   = lhs;
        sum_w = '0;
        v_f   = flags_in[1];
        c_f   = flags_in[0];
        case (op)
            OP_LDW: res = rhs;
            OP_LDB: res = {lhs[WORD_W-1:BYTE_W], rhs[BYTE_W-1:0]};
            OP_ADD: begin
                sum_w = {1'b0, lhs} + {1'b0, rhs};
                res   = sum_w[WORD_W-1:0];
                c_f   = sum_w[WORD_W];
                v_f   = (lhs[WORD_W-1] == rhs[WORD_W-1]) &&
                        (res[WORD_W-1] != lhs[WORD_W-1]);
            end
            OP_SUB: begin
                res = lhs - rhs;
                c_f = (lhs < rhs);
                v_f = (lhs[WORD_W-1] != rhs[WORD_W-1]) &&
                      (res[WORD_W-1] != lhs[WORD_W-1]);
            end
            OP_ASL: begin
                res = {lhs[WORD_W-2:0], 1'b0};
                c_f = lhs[WORD_W-1];
                v_f = lhs[WORD_W-1] ^ lhs[WORD_W-2];
            end
            OP_ASR: begin
                res = {lhs[WORD_W-1], lhs[WORD_W-1:1]};
                c_f = lhs[0];
            end
            default: res = lhs;
        endcase
        flags_out = {res[WORD_W-1], (res == '0), v_f, c_f};
    end
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [FLAG_W-1:0] nzvc,
    output logic              halted
);
    localparam core_t RESET_VAL = '{st: ST_FETCH, default: '0};

    core_t q;
    core_t d;

    logic [SPEC_W-1:0] spec_cur;
    dec_t              dec;
    logic [WORD_W-1:0] sel_reg;
    logic [WORD_W-1:0] alu_rhs;
    logic [WORD_W-1:0] alu_res;
    logic [FLAG_W-1:0] alu_flags;
    logic [ADDR_W-1:0] opnd_addr;
    logic [ADDR_W-1:0] opnd_next;
    logic              commit;

    assign spec_cur  = (q.st == ST_SPEC) ? mem_rdata : q.ir[IR_W-1:WORD_W];
    assign sel_reg   = dec.use_x ? q.x : q.a;
    assign opnd_addr = {q.ir[WORD_W-1:BYTE_W], mem_rdata};
    assign opnd_next = q.ir[WORD_W-1:0] + 1'b1;

    always_comb begin
        case (q.st)
            ST_OPLO:   alu_rhs = {q.ir[WORD_W-1:BYTE_W], mem_rdata};
            ST_RDLO:   alu_rhs = {q.tmp, mem_rdata};
            ST_RDBYTE: alu_rhs = {{(WORD_W-BYTE_W){1'b0}}, mem_rdata};
            default:   alu_rhs = '0;
        endcase
    end

    acc_decode u_dec (
        .spec (spec_cur),
        .dec  (dec)
    );

    acc_alu u_alu (
        .op        (dec.op),
        .lhs       (sel_reg),
        .rhs       (alu_rhs),
        .flags_in  (q.nzvc),
        .res       (alu_res),
        .flags_out (alu_flags)
    );

    always_comb begin
        d         = q;
        mem_addr  = '0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_wdata = '0;
        commit    = 1'b0;
        case (q.st)
            ST_FETCH: begin
                mem_addr = q.pc;
                mem_rd   = 1'b1;
                d.pc     = q.pc + 1'b1;
                d.st     = ST_SPEC;
            end
            ST_SPEC: begin
                d.ir[IR_W-1:WORD_W] = mem_rdata;
                if (dec.op == OP_HALT) begin
                    d.st = ST_HALT;
                end else if (dec.unary) begin
                    commit = 1'b1;
                    d.st   = ST_FETCH;
                end else begin
                    mem_addr = q.pc;
                    mem_rd   = 1'b1;
                    d.pc     = q.pc + 1'b1;
                    d.st     = ST_OPHI;
                end
            end
            ST_OPHI: begin
                d.ir[WORD_W-1:BYTE_W] = mem_rdata;
                mem_addr = q.pc;
                mem_rd   = 1'b1;
                d.pc     = q.pc + 1'b1;
                d.st     = ST_OPLO;
            end
            ST_OPLO: begin
                d.ir[BYTE_W-1:0] = mem_rdata;
                d.st             = ST_FETCH;
                if (dec.immed) begin
                    commit = (dec.op != OP_STW) && (dec.op != OP_STB);
                end else begin
                    case (dec.op)
                        OP_LDB: begin
                            mem_addr = opnd_addr;
                            mem_rd   = 1'b1;
                            d.st     = ST_RDBYTE;
                        end
                        OP_STW: begin
                            mem_addr  = opnd_addr;
                            mem_wr    = 1'b1;
                            mem_wdata = sel_reg[WORD_W-1:BYTE_W];
                            d.st      = ST_WRLO;
                        end
                        OP_STB: begin
                            mem_addr  = opnd_addr;
                            mem_wr    = 1'b1;
                            mem_wdata = sel_reg[BYTE_W-1:0];
                        end
                        default: begin
                            mem_addr = opnd_addr;
                            mem_rd   = 1'b1;
                            d.st     = ST_RDHI;
                        end
                    endcase
                end
            end
            ST_RDHI: begin
                d.tmp    = mem_rdata;
                mem_addr = opnd_next;
                mem_rd   = 1'b1;
                d.st     = ST_RDLO;
            end
            ST_RDLO, ST_RDBYTE: begin
                commit = 1'b1;
                d.st   = ST_FETCH;
            end
            ST_WRLO: begin
                mem_addr  = opnd_next;
                mem_wr    = 1'b1;
                mem_wdata = sel_reg[BYTE_W-1:0];
                d.st      = ST_FETCH;
            end
            default: d.st = ST_HALT;
        endcase
        if (commit) begin
            if (dec.use_x) d.x = alu_res;
            else           d.a = alu_res;
            d.nzvc = alu_flags;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RESET_VAL;
        else        q <= d;
    end

    assign nzvc   = q.nzvc;
    assign halted = (q.st == ST_HALT);
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
    import acc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [FLAG_W-1:0] nzvc,
    input logic              halted
);
    logic started_q;

    always_ff @(posedge clk) begin
        if (!rst_n) started_q <= 1'b0;
        else        started_q <= 1'b1;
    end

    // R1: first cycle out of reset fetches from address zero
    assert_first_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !started_q |-> (mem_rd && mem_addr == '0 && !halted));

    // R3: halt is sticky
    assert_halt_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R3: no memory traffic while halted
    assert_halt_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr));

    // R3: flags frozen once halted
    assert_halt_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(nzvc));

    // R7: a store cycle leaves the flags alone
    assert_store_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> $stable(nzvc));

    // R13: read and write never overlap
    assert_rw_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
endmodule

bind acc_core acc_core_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .nzvc     (nzvc),
    .halted   (halted)
);

// File: tb/acc_core_test.sv
module acc_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_N      = 4096;
    localparam int N_RAND     = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic        mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic [3:0]  nzvc;
    logic        halted;

    int total = 0;
    int bad   = 0;

    logic [7:0] mem [0:MEM_N-1];
    logic [7:0] mm  [0:MEM_N-1];
    int ptr;

    logic [15:0] m_a, m_x;
    logic [3:0]  m_f;
    int          m_cyc, m_wr;
    int          r_cyc, r_wr, r_post;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_core uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .nzvc      (nzvc),
        .halted    (halted)
    );

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < MEM_N; i++) begin
            mem[i] = 8'h00;
            mm[i]  = 8'h00;
        end
        ptr = 0;
    endtask

    task automatic poke(input int addr, input logic [7:0] b);
        mem[addr] = b;
        mm[addr]  = b;
    endtask

    task automatic emit(input logic [7:0] b);
        poke(ptr, b);
        ptr++;
    endtask

    task automatic emit3(input logic [7:0] s, input logic [15:0] w);
        emit(s);
        emit(w[15:8]);
        emit(w[7:0]);
    endtask

    function automatic logic [3:0] nz(input logic [15:0] r, input logic [1:0] vc);
        return {r[15], r == 16'h0, vc};
    endfunction

    // Sequential model of the instruction set
    task automatic model_exec();
        int pc = 0;
        logic [7:0] s;
        logic [3:0] op;
        logic [15:0] os, l, r, w;
        logic [16:0] sm;
        bit run = 1;
        bit v, c;
        m_a = 0; m_x = 0; m_f = 0; m_cyc = 0; m_wr = 0;
        while (run && m_cyc < 5000) begin
            s  = mm[pc % MEM_N];
            pc = pc + 1;
            op = s[7:4];
            if (op == 4'h1 && s[3:2] == 2'b11) begin
                l = s[0] ? m_x : m_a;
                if (!s[1]) begin
                    r = {l[14:0], 1'b0};
                    m_f = nz(r, {l[15] ^ l[14], l[15]});
                end else begin
                    r = {l[15], l[15:1]};
                    m_f = nz(r, {m_f[1], l[0]});
                end
                if (s[0]) m_x = r; else m_a = r;
                m_cyc += 2;
                continue;
            end
            if (s[2:1] != 2'b00 || !(op inside {4'h7, 4'h8, 4'hC, 4'hD, 4'hE, 4'hF})) begin
                m_cyc += 2;
                run = 0;
                break;
            end
            os = {mm[pc % MEM_N], mm[(pc + 1) % MEM_N]};
            pc = pc + 2;
            l  = s[3] ? m_x : m_a;
            r  = l;
            case (op)
                4'hC: begin
                    w = (s[0] == 1'b0) ? os : {mm[os[11:0]], mm[os[11:0] + 12'd1]};
                    r = w;
                    m_f = nz(r, m_f[1:0]);
                    m_cyc += (s[0] == 1'b0) ? 4 : 6;
                end
                4'hD: begin
                    r = {l[15:8], (s[0] == 1'b0) ? os[7:0] : mm[os[11:0]]};
                    m_f = nz(r, m_f[1:0]);
                    m_cyc += (s[0] == 1'b0) ? 4 : 5;
                end
                4'h7, 4'h8: begin
                    w = (s[0] == 1'b0) ? os : {mm[os[11:0]], mm[os[11:0] + 12'd1]};
                    if (op == 4'h7) begin
                        sm = {1'b0, l} + {1'b0, w};
                        r = sm[15:0];
                        c = sm[16];
                        v = (l[15] == w[15]) && (r[15] != l[15]);
                    end else begin
                        r = l - w;
                        c = (l < w);
                        v = (l[15] != w[15]) && (r[15] != l[15]);
                    end
                    m_f = nz(r, {v, c});
                    m_cyc += (s[0] == 1'b0) ? 4 : 6;
                end
                4'hE: begin
                    if (s[0]) begin
                        mm[os[11:0]] = l[15:8];
                        mm[os[11:0] + 12'd1] = l[7:0];
                        m_wr += 2;
                        m_cyc += 5;
                    end else m_cyc += 4;
                end
                default: begin
                    if (s[0]) begin
                        mm[os[11:0]] = l[7:0];
                        m_wr += 1;
                    end
                    m_cyc += 4;
                end
            endcase
            if (op inside {4'h7, 4'h8, 4'hC, 4'hD}) begin
                if (s[3]) m_x = r; else m_a = r;
            end
        end
    endtask

    // Reset, release, run until halt; counts cycles and writes
    task automatic run_core(input bit chk_reset);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        if (chk_reset) begin
            check(halted == 1'b0, "R1 halted in reset", halted, 0);
            check(nzvc == 4'h0, "R1 flags in reset", nzvc, 0);
            check(mem_wr == 1'b0, "R1 no write in reset", mem_wr, 0);
        end
        rst_n = 1'b1;
        #1;
        if (chk_reset) begin
            check(mem_rd && mem_addr == 16'h0, "R1 first fetch address", mem_addr, 0);
            check(halted == 1'b0 && nzvc == 4'h0, "R1 state after release",
                  {halted, nzvc}, 0);
        end
        r_cyc = 0;
        r_wr  = 0;
        while (!halted && r_cyc < 5000) begin
            if (mem_wr) r_wr++;
            @(posedge clk);
            r_cyc++;
            @(negedge clk);
        end
        r_post = 0;
        for (int i = 0; i < 8; i++) begin
            if (mem_rd || mem_wr || !halted) r_post++;
            @(negedge clk);
        end
    endtask

    task automatic run_and_compare(input string tag);
        int mism = 0;
        int first = -1;
        model_exec();
        run_core(1'b0);
        check(r_cyc == m_cyc, {"R2 cycles ", tag}, r_cyc, m_cyc);
        check(r_post == 0, {"R3 quiet after halt ", tag}, r_post, 0);
        check(r_wr == m_wr, {"R7 write count ", tag}, r_wr, m_wr);
        check(nzvc == m_f, {"R12 flags ", tag}, nzvc, m_f);
        for (int i = 0; i < MEM_N; i++) begin
            if (mem[i] !== mm[i]) begin
                mism++;
                if (first < 0) first = i;
            end
        end
        check(mism == 0, {"R13 memory image ", tag},
              (first < 0) ? 0 : {first[15:0], mem[first], 8'h00},
              (first < 0) ? 0 : {first[15:0], mm[first], 8'h00});
    endtask

    task automatic finish_prog();
        emit3(8'hE1, 16'h0F00);
        emit3(8'hE9, 16'h0F02);
        emit(8'h00);
    endtask

    function automatic logic [15:0] rnd_word();
        logic [15:0] pick [5] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};
        if ($urandom % 4 == 0) return pick[$urandom % 5];
        return 16'($urandom);
    endfunction

    task automatic build_random();
        int k;
        logic r;
        clear_mem();
        for (int i = 12'h800; i < 12'hA00; i++) poke(i, 8'($urandom));
        emit3(8'hC0, rnd_word());
        emit3(8'hC8, rnd_word());
        for (int n = 0; n < 12; n++) begin
            k = $urandom % 12;
            r = 1'($urandom);
            case (k)
                0:  emit3({4'hC, r, 3'b000}, rnd_word());
                1:  emit3({4'hC, r, 3'b001}, 16'(12'h800 + $urandom % 12'h1FF));
                2:  emit3({4'hD, r, 3'b000}, rnd_word());
                3:  emit3({4'hD, r, 3'b001}, 16'(12'h800 + $urandom % 12'h1FF));
                4:  emit3({4'h7, r, 3'b000}, rnd_word());
                5:  emit3({4'h7, r, 3'b001}, 16'(12'h800 + $urandom % 12'h1FF));
                6:  emit3({4'h8, r, 3'b000}, rnd_word());
                7:  emit3({4'h8, r, 3'b001}, 16'(12'h800 + $urandom % 12'h1FF));
                8:  emit3({4'hE, r, 3'b001}, 16'(12'h900 + $urandom % 12'h0FF));
                9:  emit3({4'hF, r, 3'b001}, 16'(12'h900 + $urandom % 12'h0FF));
                10: emit3({4'hE, r, 3'b000}, 16'(12'h900 + $urandom % 12'h0FF));
                default: emit({7'b0001_110 | 7'(($urandom % 2) << 0), r});
            endcase
        end
        finish_prog();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));

        // R1 reset and a bare stop with junk low bits (R3)
        clear_mem();
        emit(8'h07);
        emit3(8'hE1, 16'h0F00);
        run_core(1'b1);
        check(r_cyc == 2, "R3 stop 0x07 halts in 2 cycles", r_cyc, 2);
        check(r_wr == 0 && r_post == 0, "R3 nothing after stop", r_wr + r_post, 0);

        // R9 signed overflow into the sign bit
        clear_mem();
        emit3(8'hC0, 16'h7FFF); emit3(8'h70, 16'h0001); finish_prog();
        run_and_compare("add ovf");
        check(nzvc == 4'b1010, "R9 7FFF+1 flags", nzvc, 4'b1010);
        check({mem[12'hF00], mem[12'hF01]} == 16'h8000, "R9 7FFF+1 sum",
              {mem[12'hF00], mem[12'hF01]}, 16'h8000);

        // R9 wrap to zero with carry
        clear_mem();
        emit3(8'hC0, 16'hFFFF); emit3(8'h70, 16'h0001); finish_prog();
        run_and_compare("add wrap");
        check(nzvc == 4'b0101, "R9 FFFF+1 flags", nzvc, 4'b0101);

        // R10 borrow from zero, on X (R12)
        clear_mem();
        emit3(8'hC0, 16'h1234); emit3(8'hC8, 16'h0000); emit3(8'h88, 16'h0001);
        finish_prog();
        run_and_compare("sub borrow");
        check(nzvc == 4'b1001, "R10 0-1 flags", nzvc, 4'b1001);
        check({mem[12'hF02], mem[12'hF03]} == 16'hFFFF, "R10 0-1 result",
              {mem[12'hF02], mem[12'hF03]}, 16'hFFFF);
        check({mem[12'hF00], mem[12'hF01]} == 16'h1234, "R12 A untouched",
              {mem[12'hF00], mem[12'hF01]}, 16'h1234);

        // R10 signed overflow on subtract
        clear_mem();
        emit3(8'hC0, 16'h8000); emit3(8'h80, 16'h0001); finish_prog();
        run_and_compare("sub ovf");
        check(nzvc == 4'b0010, "R10 8000-1 flags", nzvc, 4'b0010);

        // R11 left shift of A (0x1C)
        clear_mem();
        emit3(8'hC0, 16'h4000); emit(8'h1C); finish_prog();
        run_and_compare("asl");
        check(nzvc == 4'b1010, "R11 asl flags", nzvc, 4'b1010);
        check({mem[12'hF00], mem[12'hF01]} == 16'h8000, "R11 asl result",
              {mem[12'hF00], mem[12'hF01]}, 16'h8000);

        // R11 right shift of X (0x1F)
        clear_mem();
        emit3(8'hC8, 16'h8001); emit(8'h1F); finish_prog();
        run_and_compare("asr");
        check(nzvc == 4'b1001, "R11 asr flags", nzvc, 4'b1001);
        check({mem[12'hF02], mem[12'hF03]} == 16'hC000, "R11 asr result",
              {mem[12'hF02], mem[12'hF03]}, 16'hC000);

        // R6 byte load keeps the upper half; flags from 16 bits
        clear_mem();
        emit3(8'hC0, 16'hAB77); emit3(8'hD0, 16'h5500); finish_prog();
        run_and_compare("ldb");
        check({mem[12'hF00], mem[12'hF01]} == 16'hAB00, "R6 byte load merge",
              {mem[12'hF00], mem[12'hF01]}, 16'hAB00);
        check(nzvc == 4'b1000, "R6 byte load flags", nzvc, 4'b1000);

        // R5 big-endian direct word load into X
        clear_mem();
        poke(12'h850, 8'h9A); poke(12'h851, 8'h0B);
        emit3(8'hC9, 16'h0850); finish_prog();
        run_and_compare("ldw dir");
        check({mem[12'hF02], mem[12'hF03]} == 16'h9A0B, "R5 byte order",
              {mem[12'hF02], mem[12'hF03]}, 16'h9A0B);
        check(nzvc == 4'b1000, "R5 load flags", nzvc, 4'b1000);

        // R7 immediate store is a no-op; R8 byte store touches one byte
        clear_mem();
        emit3(8'hC0, 16'h55AA); emit3(8'hE0, 16'h0F10);
        emit3(8'hF1, 16'h0F05); emit(8'h00);
        run_and_compare("stores");
        check(mem[12'hF10] == 8'h00 && mem[12'hF11] == 8'h00, "R7 immediate store no write",
              {mem[12'hF10], mem[12'hF11]}, 0);
        check(r_wr == 1, "R8 single byte write", r_wr, 1);
        check({mem[12'hF04], mem[12'hF05], mem[12'hF06]} == 24'h00AA00, "R8 byte store",
              {mem[12'hF04], mem[12'hF05], mem[12'hF06]}, 24'h00AA00);

        // R4 unimplemented opcode, illegal mode, bad 0001 encoding
        clear_mem();
        emit3(8'hC0, 16'h1111); emit(8'h20); emit3(8'hE1, 16'h0F00); emit(8'h00);
        run_and_compare("bad op");
        check(r_wr == 0 && mem[12'hF00] == 8'h00, "R4 opcode 0010 halts", r_wr, 0);
        check(r_cyc == 6, "R4 halt timing", r_cyc, 6);

        clear_mem();
        emit3(8'hC2, 16'h0000); emit3(8'hE1, 16'h0F00); emit(8'h00);
        run_and_compare("bad mode");
        check(r_cyc == 2 && r_wr == 0, "R4 mode 010 halts", r_cyc, 2);

        clear_mem();
        emit(8'h1A); emit3(8'hE1, 16'h0F00); emit(8'h00);
        run_and_compare("bad unary");
        check(r_cyc == 2 && r_wr == 0, "R4 0x1A halts", r_cyc, 2);

        // Random programs against the model (R2, R5-R13)
        for (int t = 0; t < N_RAND; t++) begin
            build_random();
            run_and_compare($sformatf("random %0d", t));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule